// File: doc/BRIEF.md
# Indirect Extended Register Access Port

This block lets a 32-bit host register bus reach a separate extended register space through two host-visible registers. The data register sits at byte offset 0x70 and the command register at byte offset 0x74. Writing the command register starts one full-word transaction toward one of three target spaces. Bit 31 of that write selects the direction. The same bit, read back, tells the host how far the transaction has got. A write reads 1 while it is in flight and 0 once it is done. A read reads 0 until the word has arrived and 1 once it is in the data register.

On the back end the block raises one valid/ready request. The request carries a word-aligned address, the target select, byte lanes, a write flag and write data. The target answers with a response strobe that carries read data, after any number of cycles. The host polls bit 31 and gives up after roughly 10 ms, so the target must answer well within that time.

Top module: `xrw_port`

## Requirements
- R1: After reset, the data register reads 0, the command register reads 0 (bit 31 = 0, idle and not busy), and `req_valid` is low.
- R2: A command write (offset 0x74) while idle raises `req_valid` on the next cycle. `req_write` equals bit 31 of the written word, and a write carries the data-register word as it stood at the command write.
- R3: For a write command, bit 31 reads 1 from the cycle after the command write until the cycle after the accepted response, and then reads 0.
- R4: For a read command (bit 31 = 0), `req_be` is 4'hF and bit 31 reads 0 until the response is taken.
- R5: When a read response is taken, from the next cycle bit 31 reads 1 and the data register holds `rsp_rdata`.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid` and every request field stay unchanged.
- R7: A command write while a transaction is in flight (request pending or response awaited) is ignored: no new request, and the command read-back fields do not change.
- R8: Host data-register writes during a write transaction update the data register but not `req_wdata`.
- R9: `req_addr` is the command address field bits 11:2 with bits 1:0 forced to 0.
- R10: `rsp_valid` counts only after the request handshake. A read response takes precedence over a host data-register write in the same cycle.
- R11: The command register reads back {status, 13'b0, space[1:0] at bits 17:16, lanes[3:0] at bits 15:12, aligned address at bits 11:0}. Lanes are passed to `req_be` only on writes. Space codes are 0 = extended MAC space, 1 = interrupt-vector space, and 2 = management space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_wr | input | 1 | Host write strobe |
| hst_waddr | input | HOST_AW | Host write byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_raddr | input | HOST_AW | Host read byte offset |
| hst_rdata | output | 32 | Host read data (combinational) |
| req_valid | output | 1 | Back-end request valid |
| req_ready | input | 1 | Back-end request accepted |
| req_addr | output | 12 | Word-aligned target address |
| req_space | output | 2 | Target space select |
| req_be | output | 4 | Byte lanes (bit 0 = lowest byte) |
| req_write | output | 1 | 1 = write, 0 = read |
| req_wdata | output | 32 | Captured write word |
| rsp_valid | input | 1 | Response strobe |
| rsp_rdata | input | 32 | Read data with the response |

## Verification
A corrupted phase register shows up at once: either `req_valid` rises without a command or never falls, or bit 31 of the command read-back takes the wrong value within one cycle of the handshake or response. A wrong captured word or field shows on the request outputs in the first cycle `req_valid` is high. Bad read-data capture shows in the data register on the cycle after the response. The reference model is compared on every clock, so the fault is seen in the cycle it first shows at the ports.

// File: rtl/xrw_pkg.sv
// Shared constants and types for the indirect extended register port.
// Assumes a byte-addressed host bus and a 12-bit word-aligned target space.
package xrw_pkg;
    localparam int XADDR_W = 12;
    localparam int LANES   = 4;
    localparam int WORD_W  = 8 * LANES;

    typedef enum logic [1:0] {
        SPACE_MAC  = 2'd0,
        SPACE_VEC  = 2'd1,
        SPACE_MGMT = 2'd2,
        SPACE_RSVD = 2'd3
    } xrw_space_e;

    typedef struct packed {
        logic               go;
        xrw_space_e         space;
        logic [LANES-1:0]   lanes;
        logic [XADDR_W-1:0] addr;
    } xrw_cmd_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_WAIT  = 2'd2
    } xrw_phase_e;
endpackage

// File: rtl/xrw_cmd_decode.sv
// Splits the used bits of a command word into a typed command.
// The address is forced to a word boundary. No storage, pure logic.
module xrw_cmd_decode
    import xrw_pkg::*;
(
    input  logic [16:0] cmd_bits,   // {word[31], word[17:2]}
    output xrw_cmd_t    cmd
);
    // field split of the command word
    always_comb begin
        cmd.go    = cmd_bits[16];
        cmd.space = xrw_space_e'(cmd_bits[15:14]);
        cmd.lanes = cmd_bits[13:10];
        cmd.addr  = {cmd_bits[9:0], 2'b00};
    end
endmodule

// File: rtl/xrw_txn_ctrl.sv
// Runs one back-end transaction at a time: it issues the request, waits
// for the response and keeps the status bit.
// Assumes the response comes only after the request handshake.
module xrw_txn_ctrl
    import xrw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  xrw_cmd_t           cmd_in,
    input  logic [WORD_W-1:0]  word_in,
    input  logic               req_ready,
    input  logic               rsp_valid,
    input  logic [WORD_W-1:0]  rsp_rdata,
    output logic               status,
    output xrw_cmd_t           cmd_held,
    output logic               req_valid,
    output logic [XADDR_W-1:0] req_addr,
    output logic [1:0]         req_space,
    output logic [LANES-1:0]   req_be,
    output logic               req_write,
    output logic [WORD_W-1:0]  req_wdata,
    output logic               rd_done,
    output logic [WORD_W-1:0]  rd_word
);
    xrw_phase_e phase;
    logic       take;
    logic       done;

    assign take = (phase == PH_IDLE) && launch;
    assign done = (phase == PH_WAIT) && rsp_valid;

    // phase sequencing: idle -> issue -> wait -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE:  if (launch)    phase <= PH_ISSUE;
                PH_ISSUE: if (req_ready) phase <= PH_WAIT;
                PH_WAIT:  if (rsp_valid) phase <= PH_IDLE;
                default:                 phase <= PH_IDLE;
            endcase
        end
    end

    // capture the command and the outgoing word at launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_held  <= '0;
            req_wdata <= '0;
        end else if (take) begin
            cmd_held  <= cmd_in;
            req_wdata <= word_in;
        end
    end

    // status bit: set to direction at launch, resolved on response
    always_ff @(posedge clk) begin
        if (!rst_n)    status <= 1'b0;
        else if (take) status <= cmd_in.go;
        else if (done) status <= ~cmd_held.go;
    end

    // request outputs derived from the held command
    always_comb begin
        req_valid = (phase == PH_ISSUE);
        req_addr  = cmd_held.addr;
        req_space = cmd_held.space;
        req_write = cmd_held.go;
        req_be    = cmd_held.go ? cmd_held.lanes : {LANES{1'b1}};
        rd_done   = done && !cmd_held.go;
        rd_word   = rsp_rdata;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_wdata)
                                    && $stable(req_be) && $stable(req_write)); // R6
    AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) && launch |=> $stable(cmd_held)); // R7
    AST_WR_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write |-> status); // R3
    AST_RD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |-> req_be == {LANES{1'b1}} && !status); // R4
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_addr[1:0] == 2'b00); // R9
    AST_RD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> status && (phase == PH_IDLE)); // R5
endmodule

// File: rtl/xrw_port.sv
// Host-facing top of the indirect extended register port. It holds the data
// register, decodes host writes and muxes host reads.
// Assumes a single-cycle host write strobe and combinational host reads.
module xrw_port
    import xrw_pkg::*;
#(
    parameter int HOST_AW  = 8,
    parameter int DATA_OFS = 'h70,
    parameter int CMD_OFS  = 'h74
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_wr,
    input  logic [HOST_AW-1:0] hst_waddr,
    input  logic [31:0]        hst_wdata,
    input  logic [HOST_AW-1:0] hst_raddr,
    output logic [31:0]        hst_rdata,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [11:0]        req_addr,
    output logic [1:0]         req_space,
    output logic [3:0]         req_be,
    output logic               req_write,
    output logic [31:0]        req_wdata,
    input  logic               rsp_valid,
    input  logic [31:0]        rsp_rdata
);
    localparam logic [HOST_AW-1:0] DATA_SEL = HOST_AW'(DATA_OFS);
    localparam logic [HOST_AW-1:0] CMD_SEL  = HOST_AW'(CMD_OFS);

    logic [WORD_W-1:0] data_q;
    logic              data_wr;
    logic              cmd_wr;
    xrw_cmd_t          cmd_dec;
    xrw_cmd_t          cmd_held;
    logic              status;
    logic              rd_done;
    logic [WORD_W-1:0] rd_word;

    assign data_wr = hst_wr && (hst_waddr == DATA_SEL);
    assign cmd_wr  = hst_wr && (hst_waddr == CMD_SEL);

    xrw_cmd_decode u_dec (
        .cmd_bits ({hst_wdata[31], hst_wdata[17:2]}),
        .cmd      (cmd_dec)
    );

    xrw_txn_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (cmd_wr),
        .cmd_in    (cmd_dec),
        .word_in   (data_q),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .status    (status),
        .cmd_held  (cmd_held),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_space (req_space),
        .req_be    (req_be),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .rd_done   (rd_done),
        .rd_word   (rd_word)
    );

    // data register: read response wins over a host write
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (rd_done) data_q <= rd_word;
        else if (data_wr) data_q <= hst_wdata;
    end

    // host read mux
    always_comb begin
        if (hst_raddr == DATA_SEL)
            hst_rdata = data_q;
        else if (hst_raddr == CMD_SEL)
            hst_rdata = {status, 13'b0, cmd_held.space, cmd_held.lanes, cmd_held.addr};
        else
            hst_rdata = '0;
    end

    AST_RD_PRECEDENCE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done && data_wr |=> data_q == $past(rsp_rdata)); // R10
    AST_WDATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && $past(req_valid) |-> $stable(req_wdata)); // R8
endmodule

// File: tb/xrw_port_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model stepped on every clock and compared
// at the ports on every falling edge.
module xrw_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wr = 1'b0;
    logic [7:0]  hst_waddr = '0;
    logic [31:0] hst_wdata = '0;
    logic [7:0]  hst_raddr = '0;
    logic [31:0] hst_rdata;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [11:0] req_addr;
    logic [1:0]  req_space;
    logic [3:0]  req_be;
    logic        req_write;
    logic [31:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_rdata = '0;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // model state
    int        m_phase;
    bit        m_status;
    bit        m_go;
    bit [1:0]  m_space;
    bit [3:0]  m_lanes;
    bit [11:0] m_addr;
    bit [31:0] m_wword;
    bit [31:0] m_data;

    always #2.5 clk = ~clk;

    xrw_port dut_i (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_waddr(hst_waddr),
        .hst_wdata(hst_wdata), .hst_raddr(hst_raddr), .hst_rdata(hst_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_space(req_space), .req_be(req_be), .req_write(req_write),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%08h exp=%08h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic bit [31:0] m_cmd_view();
        return {m_status, 13'b0, m_space, m_lanes, m_addr};
    endfunction

    task automatic m_reset();
        m_phase = 0; m_status = 0; m_go = 0; m_space = 0;
        m_lanes = 0; m_addr = 0; m_wword = 0; m_data = 0;
    endtask

    // one model step from the inputs the bench drove for this edge
    task automatic m_step();
        bit [31:0] d_old = m_data;
        bit rd_take = (m_phase == 2) && rsp_valid && !m_go;
        case (m_phase)
            0: if (hst_wr && hst_waddr == 8'h74) begin
                   m_go = hst_wdata[31]; m_space = hst_wdata[17:16];
                   m_lanes = hst_wdata[15:12]; m_addr = {hst_wdata[11:2], 2'b00};
                   m_wword = d_old; m_status = hst_wdata[31]; m_phase = 1;
               end
            1: if (req_ready) m_phase = 2;
            2: if (rsp_valid) begin
                   m_phase = 0;
                   m_status = !m_go;
               end
            default: m_phase = 0;
        endcase
        if (rd_take) m_data = rsp_rdata;
        else if (hst_wr && hst_waddr == 8'h70) m_data = hst_wdata;
    endtask

    // compare all outputs against the model (called near the falling edge)
    task automatic compare_all();
        hst_raddr = 8'h70; #0.2;
        chk("R5 data", hst_rdata, m_data);
        hst_raddr = 8'h74; #0.2;
        chk("R3 cmd", hst_rdata, m_cmd_view());
        chk("R2 valid", {31'b0, req_valid}, {31'b0, m_phase == 1});
        if (m_phase == 1) begin
            chk("R2 write", {31'b0, req_write}, {31'b0, m_go});
            chk("R9 addr", {20'b0, req_addr}, {20'b0, m_addr});
            chk("R11 space", {30'b0, req_space}, {30'b0, m_space});
            chk("R4 be", {28'b0, req_be}, {28'b0, (m_go ? m_lanes : 4'hF)});
            if (m_go) chk("R8 wdata", req_wdata, m_wword);
        end
    endtask

    // one cycle: check, drive, edge, model step
    task automatic cyc(bit wr, bit [7:0] wa, bit [31:0] wd, bit rdy, bit rv, bit [31:0] rd);
        compare_all();
        hst_wr = wr; hst_waddr = wa; hst_wdata = wd;
        req_ready = rdy; rsp_valid = rv; rsp_rdata = rd;
        @(posedge clk);
        m_step();
        @(negedge clk);
    endtask

    initial begin
        m_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        hst_raddr = 8'h70; #0.2; chk("R1 data", hst_rdata, 32'h0);
        hst_raddr = 8'h74; #0.2; chk("R1 cmd", hst_rdata, 32'h0);
        chk("R1 valid", {31'b0, req_valid}, 32'h0);

        // write transaction with stalls, stray response, busy writes
        cyc(1, 8'h70, 32'hCAFE_1234, 0, 0, 0);
        cyc(1, 8'h74, 32'h8002_A3F7, 0, 0, 0);
        // R11 field layout: space 2, lanes A, addr 3F4, status 1
        hst_raddr = 8'h74; #0.2; chk("R11 layout", hst_rdata, 32'h8002_A3F4);
        cyc(0, 8'h00, 0, 0, 1, 32'h1111_1111);            // R10 stray response ignored
        cyc(1, 8'h70, 32'hDEAD_0000, 0, 0, 0);            // R8 data write while busy
        cyc(1, 8'h74, 32'h0001_F010, 0, 0, 0);            // R7 command while busy
        chk("R6 still valid", {31'b0, req_valid}, 32'h1);
        chk("R8 word kept", req_wdata, 32'hCAFE_1234);
        cyc(0, 8'h00, 0, 1, 0, 0);
        cyc(1, 8'h74, 32'h0001_F010, 0, 0, 0);            // R7 command while waiting
        chk("R7 no new req", {31'b0, req_valid}, 32'h0);
        cyc(0, 8'h00, 0, 0, 1, 0);
        hst_raddr = 8'h74; #0.2; chk("R3 write done", {31'b0, hst_rdata[31]}, 32'h0);

        // read transaction, response collides with host data write
        cyc(1, 8'h74, 32'h0000_0008, 0, 0, 0);
        hst_raddr = 8'h74; #0.2; chk("R4 read pending", {31'b0, hst_rdata[31]}, 32'h0);
        cyc(0, 8'h00, 0, 1, 0, 0);
        cyc(1, 8'h70, 32'h5555_5555, 0, 1, 32'h1234_ABCD);
        hst_raddr = 8'h70; #0.2; chk("R10 precedence", hst_rdata, 32'h1234_ABCD);
        hst_raddr = 8'h74; #0.2; chk("R5 ready bit", {31'b0, hst_rdata[31]}, 32'h1);

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom % 3;
            bit [7:0] wa = (sel == 0) ? 8'h70 : (sel == 1) ? 8'h74 : 8'h10;
            cyc(($urandom % 4) == 0, wa, $urandom, ($urandom % 3) != 0,
                ($urandom % 4) == 0, $urandom);
        end
        compare_all();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule